// File: doc/BRIEF.md
# Prescaled Dual-Channel PWM Generator

This block produces two independent pulse-width modulated outputs from a single input clock. Each channel owns a small register bank that holds a clock divider value, a period length, a high-time count, a flag that forces the output fully on, and a bit that selects how the channel stops. The divided clock ticks step a period counter. The output stays high while that counter is below the programmed high-time count, so one period spans (divider + 1) × (period value + 1) input cycles.

Software programs the channels over a plain word-wide register bus. The bus has an address, write data, a write strobe and combinational read data. A per-channel enable input starts and stops each channel. New settings take effect only at a period boundary, so a running output never shows a clipped pulse. Only normal polarity is produced: high first, then low.

Top module: `pwmx_dual`

## Requirements
- R1: One output period lasts exactly (PRE + 1) × (PV + 1) input clock cycles, where PRE is the 6-bit divider and PV is the 10-bit period value. The output pattern then repeats.
- R2: The output is high for the first (PRE + 1) × DC cycles of every period and low for the rest, where DC is the 10-bit high-time count.
- R3: When the full-on flag is set, the output stays high for every cycle of the period, whatever DC and the counter hold.
- R4: With the full-on flag clear, DC = 0 gives a constantly low output, and DC > PV + 1 gives a constantly high output.
- R5: Channel n has its bank at byte address n × 0x10. Offset 0x00 is control: PRE in bits [5:0] and the stop-mode bit in bit 6. Offset 0x04 is duty: DC in bits [9:0] and the full-on flag in bit 10. Offset 0x08 is period: PV in bits [9:0]. Reads return the stored fields with all other bits zero, and reads of unmapped offsets return zero.
- R6: A divider, duty or period value written while a channel runs is applied only from the start of the next period. The period in progress keeps its old shape.
- R7: While the stop-mode bit is set, dropping the enable drives the output low in the same cycle and freezes the counters. Raising the enable again resumes from the frozen position.
- R8: While the stop-mode bit is clear, dropping the enable lets the current period finish unchanged. The output then stays low. A later enable starts at the beginning of a period.
- R9: A channel that is disabled and parked at a period boundary drives its output low and does not disturb the other channel.
- R10: After reset all register fields read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| ch_en | input | NUM_CH (2) | Per-channel enable |
| pwm_out | output | NUM_CH (2) | Per-channel PWM output |

## Verification
Read data is combinational, so the bench samples it one time step after it sets the address. A register write lands on the next rising edge. A parked channel copies the new settings one edge after that, which is why two cycles pass between the last write and an enable. The output follows the counter state with no added register, and it reacts to the enable within the same cycle. The bench therefore numbers cycles from the falling edge at which the enable rises: cycle 0 is the first position of the period. It samples each cycle one step after that falling edge and compares against (position mod period) / (PRE + 1) < DC. A change written during cycle k of a period is expected from the first cycle of the next period.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

    localparam int PRE_W = 6;
    localparam int CNT_W = 10;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             halt_now;
        logic [CNT_W-1:0] dc;
        logic             full;
        logic [CNT_W-1:0] pv;
    } chan_cfg_t;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pcnt;
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] a_pre;
        logic [CNT_W-1:0] a_dc;
        logic             a_full;
        logic [CNT_W-1:0] a_pv;
    } chan_st_t;

endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_we,
    output logic [DATA_W-1:0]        bus_rdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

    localparam int BANK_W = ADDR_W - 4;
    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_DUTY = 4'h4;
    localparam logic [3:0] OFF_PER  = 4'h8;

    chan_cfg_t [NUM_CH-1:0] cfg_d, cfg_q;
    logic [BANK_W-1:0]      bank;
    logic [3:0]             off;
    wire                    unused_wd = ^bus_wdata[DATA_W-1:CNT_W+1];

    assign bank = bus_addr[ADDR_W-1:4];
    assign off  = bus_addr[3:0];

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (bank == BANK_W'(c)) begin
                    case (off)
                        OFF_CTRL: begin
                            cfg_d[c].pre      = bus_wdata[PRE_W-1:0];
                            cfg_d[c].halt_now = bus_wdata[PRE_W];
                        end
                        OFF_DUTY: begin
                            cfg_d[c].dc   = bus_wdata[CNT_W-1:0];
                            cfg_d[c].full = bus_wdata[CNT_W];
                        end
                        OFF_PER: cfg_d[c].pv = bus_wdata[CNT_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bank == BANK_W'(c)) begin
                case (off)
                    OFF_CTRL: bus_rdata[PRE_W:0]  = {cfg_q[c].halt_now, cfg_q[c].pre};
                    OFF_DUTY: bus_rdata[CNT_W:0]  = {cfg_q[c].full, cfg_q[c].dc};
                    OFF_PER:  bus_rdata[CNT_W-1:0] = cfg_q[c].pv;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bank == '0 && off == OFF_CTRL) |=> (cfg_q[0].pre == $past(bus_wdata[PRE_W-1:0]))); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (off != OFF_CTRL && off != OFF_DUTY && off != OFF_PER) |-> (bus_rdata == '0)); // R5

endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      run_en,
    output logic      pwm_o
);

    chan_st_t st_d, st_q;
    logic     go, tick, wrap, eop;

    always_comb begin
        go   = run_en | (st_q.run & ~cfg.halt_now);
        tick = (st_q.pcnt == st_q.a_pre);
        wrap = (st_q.cnt == st_q.a_pv);
        eop  = go & tick & wrap;
        st_d = st_q;
        if (go) begin
            st_d.pcnt = tick ? '0 : st_q.pcnt + PRE_W'(1);
            if (tick) st_d.cnt = wrap ? '0 : st_q.cnt + CNT_W'(1);
            st_d.run = run_en | ~eop;
        end
        if (eop || (!go && !st_q.run)) begin
            st_d.a_pre  = cfg.pre;
            st_d.a_dc   = cfg.dc;
            st_d.a_full = cfg.full;
            st_d.a_pv   = cfg.pv;
        end
        pwm_o = go & (st_q.a_full | (st_q.cnt < st_q.a_dc));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !eop) |=> ($stable(st_q.a_pv) && $stable(st_q.a_dc) && $stable(st_q.a_pre) && $stable(st_q.a_full))); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && cfg.halt_now) |=> ($stable(st_q.cnt) && $stable(st_q.pcnt))); // R7
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && cfg.halt_now) |-> !pwm_o); // R7
    AST_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (eop && !run_en) |=> (!st_q.run && st_q.cnt == '0 && st_q.pcnt == '0)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt <= st_q.a_pv && st_q.pcnt <= st_q.a_pre)); // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !run_en) |-> !pwm_o); // R9

endmodule

// File: rtl/pwmx_dual.sv
module pwmx_dual
    import pwmx_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0] cfg;

    pwmx_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmx_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg    (cfg[g]),
            .run_en (ch_en[g]),
            .pwm_o  (pwm_out[g])
        );
    end

endmodule

// File: tb/pwmx_dual_bench.sv
module pwmx_dual_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  ch_en = '0;
    logic [1:0]  pwm_out;
    int          n_cmp = 0;
    int          n_bad = 0;

    pwmx_dual u_pwmx_dual (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ch_en(ch_en), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_out(int pre, int pv, int dc, int full, int pos);
        int p;
        p = pos % ((pre + 1) * (pv + 1));
        return (full != 0 || (p / (pre + 1)) < dc) ? 1 : 0;
    endfunction

    task automatic wr(input int a, input int d);
        bus_addr = 5'(a); bus_wdata = 32'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        bus_addr = 5'(a);
        #1 check(req, int'(bus_rdata), exp);
    endtask

    task automatic setup(input int ch, input int ctrl, input int duty, input int per);
        wr(ch * 16 + 0, ctrl);
        wr(ch * 16 + 4, duty);
        wr(ch * 16 + 8, per);
        idle(2);
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int pres[3] = '{0, 1, 3};
        int pvs[3]  = '{0, 1, 3};
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        for (int ch = 0; ch < 2; ch++) begin
            rd_chk("R10", ch * 16 + 0, 0);
            rd_chk("R10", ch * 16 + 4, 0);
            rd_chk("R10", ch * 16 + 8, 0);
        end
        check("R10", int'(pwm_out), 0);
        @(negedge clk);

        // R5 register map and field masks
        for (int ch = 0; ch < 2; ch++) begin
            wr(ch * 16 + 0, 32'hFFFF_FFFF);
            wr(ch * 16 + 4, 32'hFFFF_FFFF);
            wr(ch * 16 + 8, 32'hFFFF_FFFF);
            rd_chk("R5", ch * 16 + 0, 32'h7F);
            rd_chk("R5", ch * 16 + 4, 32'h7FF);
            rd_chk("R5", ch * 16 + 8, 32'h3FF);
            rd_chk("R5", ch * 16 + 12, 0);
            @(negedge clk);
        end
        wr(0, 5);
        rd_chk("R5", 16, 32'h7F);
        @(negedge clk);

        // R1 R2 R3 R4 R9 sweep over small configurations, both channels
        for (int ch = 0; ch < 2; ch++) begin
            setup(1 - ch, 0, 0, 0);
            for (int ip = 0; ip < 3; ip++) begin
                for (int iv = 0; iv < 3; iv++) begin
                    for (int dc = 0; dc <= pvs[iv] + 2; dc++) begin
                        for (int full = 0; full < 2; full++) begin
                            int pre, pv, per;
                            string tag;
                            pre = pres[ip]; pv = pvs[iv];
                            per = (pre + 1) * (pv + 1);
                            if (full != 0) tag = "R3";
                            else if (dc == 0 || dc > pv + 1) tag = "R4";
                            else if (dc == 1) tag = "R1";
                            else tag = "R2";
                            setup(ch, pre, dc | (full << 10), pv);
                            #1 check("R9", int'(pwm_out), 0);
                            @(negedge clk);
                            ch_en[ch] = 1'b1;
                            for (int t = 0; t < 2 * per; t++) begin
                                #1;
                                check(tag, int'(pwm_out[ch]), exp_out(pre, pv, dc, full, t));
                                check("R9", int'(pwm_out[1 - ch]), 0);
                                @(negedge clk);
                            end
                            ch_en[ch] = 1'b0;
                            idle(per + 2);
                        end
                    end
                end
            end
        end

        // R6 update mid-period takes effect at next period
        setup(0, 0, 2, 3);
        ch_en[0] = 1'b1;
        for (int t = 0; t < 12; t++) begin
            #1 check("R6", int'(pwm_out[0]), (t < 4) ? ((t < 2) ? 1 : 0) : 1);
            if (t == 1) begin
                bus_addr = 5'd4; bus_wdata = 32'd4; bus_we = 1'b1;
            end
            @(negedge clk);
            bus_we = 1'b0;
        end
        ch_en[0] = 1'b0;
        idle(10);

        // R7 immediate stop freezes counters
        setup(0, 1 | 64, 2, 3);
        ch_en[0] = 1'b1;
        for (int t = 0; t < 3; t++) begin
            #1 check("R7", int'(pwm_out[0]), exp_out(1, 3, 2, 0, t));
            @(negedge clk);
        end
        ch_en[0] = 1'b0;
        for (int k = 0; k < 5; k++) begin
            #1 check("R7", int'(pwm_out[0]), 0);
            @(negedge clk);
        end
        ch_en[0] = 1'b1;
        for (int t = 3; t < 16; t++) begin
            #1 check("R7", int'(pwm_out[0]), exp_out(1, 3, 2, 0, t));
            @(negedge clk);
        end
        wr(0, 1);
        ch_en[0] = 1'b0;
        idle(20);

        // R8 graceful stop completes the period, then restarts clean
        ch_en[0] = 1'b1;
        for (int t = 0; t < 2; t++) begin
            #1 check("R8", int'(pwm_out[0]), exp_out(1, 3, 2, 0, t));
            @(negedge clk);
        end
        ch_en[0] = 1'b0;
        for (int t = 2; t < 13; t++) begin
            #1 check("R8", int'(pwm_out[0]), (t < 8) ? exp_out(1, 3, 2, 0, t) : 0);
            @(negedge clk);
        end
        ch_en[0] = 1'b1;
        for (int t = 0; t < 8; t++) begin
            #1 check("R8", int'(pwm_out[0]), exp_out(1, 3, 2, 0, t));
            @(negedge clk);
        end
        ch_en[0] = 1'b0;
        idle(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule